// File: doc/BRIEF.md
# Status Packet Generator

This block reports a status word of configurable width to a shared byte-wide status bus. It does not drive the bus until it owns it. When a report is due it raises a request and presents its own register address. A downstream arbiter answers with a one-cycle start pulse once it has taken that address byte. The block then streams the remaining bytes on consecutive cycles and releases the bus.

The first data byte carries a 6-bit sequence number next to the two lowest status bits. The receiver can use that number to pair each report with the command that caused it. The sequence number steps once per packet, and software can reload it together with the mode through an 8-bit control write. In single-shot mode, one packet goes out for each control write. In automatic mode, a packet goes out on entry to the mode and again each time the status differs from the last reported snapshot.

Top module: `status_pkt_gen`

## Requirements
- R1: After reset, `pkt_req` is 0, `pkt_byte` is 0x00, the mode is off and the sequence number is 0.
- R2: A write on `ctrl_we` takes `ctrl_data[1:0]` as the mode and `ctrl_data[7:2]` as the new sequence number. Mode 0 is off, 1 is single-shot and 3 is automatic.
- R3: While a send is due and no packet is in progress, `pkt_req` rises and stays high until `pkt_start` is sampled high. While `pkt_req` is high, `pkt_byte` equals the `STATUS_ADDR` parameter (default 0x31).
- R4: `pkt_req` is low in the cycle after `pkt_start` is taken. On successive cycles `pkt_byte` then carries `{seq[5:0], status[1:0]}`, followed by `status[9:2]`, `status[17:10]` and `status[25:18]`, in that order. Only ceil((PAYLOAD_BITS-2)/8) status bytes are sent, bits above PAYLOAD_BITS read as 0, and `pkt_byte` returns to 0x00 in the cycle after the last byte.
- R5: Every byte of a packet comes from the status sampled on the clock edge where `pkt_start` is taken. A later change of `status` does not alter the bytes still to be sent.
- R6: Single-shot mode sends exactly one packet per control write. Status changes after that packet raise no request.
- R7: Automatic mode sends one packet on entry and one each time `status` differs from the last snapshot sent. A change during a packet raises a new request after that packet ends.
- R8: The sequence number increments by one, wrapping from 63 to 0, after each packet. A control write reloads it.
- R9: In mode 0 and in the reserved mode 2, no request is raised whatever `status` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_data | input | 8 | Control byte: mode in [1:0], sequence number in [7:2] |
| status | input | PAYLOAD_BITS | Status word to report |
| pkt_byte | output | 8 | Packet byte to the status bus |
| pkt_req | output | 1 | Bus request |
| pkt_start | input | 1 | Arbiter acknowledge of the address byte |

## Verification
On every cycle, the assertions check the handshake:
- the request falls right after it is acknowledged;
- the address byte is shown for as long as the request is high;
- the bus reads zero when idle;
- the snapshot holds through a packet;
- the sequence number steps after each packet.

Other behaviour is visible only in the bench's directed scenarios: the byte contents and their order, the once-only behaviour of single-shot mode, the silence of the off and reserved modes, and the follow-up packet after a change during a send.

// File: rtl/status_pkt_pkg.sv
package status_pkt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SEND = 2'd2
  } pkt_state_t;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_ONCE = 2'd1;
  localparam logic [1:0] MODE_AUTO = 2'd3;

  // number of status bytes that follow the sequence byte (at least one)
  function automatic int trail_bytes(input int bits);
    int n;
    n = (bits - 2 + 7) / 8;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/status_pkt_cfg.sv
module status_pkt_cfg
  import status_pkt_pkg::*;
#(
  parameter int SEQ_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [SEQ_W+1:0] ctrl_data,
  input  logic             pkt_taken,
  input  logic             pkt_done,
  input  logic             status_diff,
  output logic             send_pending,
  output logic [SEQ_W-1:0] seq
);

  logic [1:0] mode;
  logic       once_pend;
  logic       auto_kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_OFF;
      once_pend <= 1'b0;
      auto_kick <= 1'b0;
      seq       <= '0;
    end else if (ctrl_we) begin
      mode      <= ctrl_data[1:0];
      seq       <= ctrl_data[SEQ_W+1:2];
      once_pend <= (ctrl_data[1:0] == MODE_ONCE);
      auto_kick <= (ctrl_data[1:0] == MODE_AUTO);
    end else begin
      if (pkt_taken) begin
        once_pend <= 1'b0;
        auto_kick <= 1'b0;
      end
      if (pkt_done) seq <= seq + 1'b1;
    end
  end

  assign send_pending = once_pend ||
                        ((mode == MODE_AUTO) && (auto_kick || status_diff));

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && !ctrl_we) |=> (seq == SEQ_W'($past(seq) + 1'b1)));

  // R6
  once_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_taken && !ctrl_we) |=> !once_pend);

endmodule

// File: rtl/status_pkt_bytes.sv
module status_pkt_bytes #(
  parameter int PAYLOAD_BITS = 15,
  parameter int NT           = 2,
  parameter int IW           = 2
) (
  input  logic [PAYLOAD_BITS-1:0] snap,
  input  logic [IW-1:0]           idx,
  output logic [7:0]              trail_byte
);

  localparam int PW = 2 + 8 * NT;

  logic [PW-1:0] padded;
  logic [7:0]    tb [NT+1];

  assign padded = PW'(snap);
  assign tb[0]  = 8'h00;

  for (genvar j = 1; j <= NT; j++) begin : g_trail
    assign tb[j] = padded[8*j-6 +: 8];
  end

  always_comb begin
    trail_byte = 8'h00;
    for (int k = 1; k <= NT; k++) begin
      if (idx == IW'(k)) trail_byte = tb[k];
    end
  end

endmodule

// File: rtl/status_pkt_fsm.sv
module status_pkt_fsm
  import status_pkt_pkg::*;
#(
  parameter int          PAYLOAD_BITS = 15,
  parameter logic [7:0]  STATUS_ADDR  = 8'h31,
  parameter int          SEQ_W        = 6,
  parameter int          NT           = 2,
  parameter int          IW           = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    send_pending,
  input  logic                    pkt_start,
  input  logic [PAYLOAD_BITS-1:0] status,
  input  logic [SEQ_W-1:0]        seq,
  input  logic [7:0]              trail_byte,
  output logic                    pkt_req,
  output logic [7:0]              pkt_byte,
  output logic [PAYLOAD_BITS-1:0] snap,
  output logic [IW-1:0]           idx,
  output logic                    pkt_taken,
  output logic                    pkt_done
);

  localparam logic [IW-1:0] LAST = IW'(NT);

  pkt_state_t state;

  assign pkt_taken = (state == ST_REQ) && pkt_start;
  assign pkt_done  = (state == ST_SEND) && (idx > LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pkt_req  <= 1'b0;
      pkt_byte <= 8'h00;
      snap     <= '0;
      idx      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (send_pending) begin
            state    <= ST_REQ;
            pkt_req  <= 1'b1;
            pkt_byte <= STATUS_ADDR;
          end
        end
        ST_REQ: begin
          if (pkt_start) begin
            state    <= ST_SEND;
            pkt_req  <= 1'b0;
            snap     <= status;
            pkt_byte <= {seq, status[1:0]};
            idx      <= IW'(1);
          end
        end
        ST_SEND: begin
          if (idx > LAST) begin
            state    <= ST_IDLE;
            pkt_byte <= 8'h00;
            idx      <= '0;
          end else begin
            pkt_byte <= trail_byte;
            idx      <= idx + 1'b1;
          end
        end
        default: begin
          state    <= ST_IDLE;
          pkt_req  <= 1'b0;
          pkt_byte <= 8'h00;
        end
      endcase
    end
  end

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_req && pkt_start) |=> !pkt_req);

  // R3
  addr_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_req |-> (pkt_byte == STATUS_ADDR));

  // R3
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_req) |-> $past(send_pending));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (pkt_byte == 8'h00 && !pkt_req));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && $past(state) == ST_SEND) |-> $stable(snap));

endmodule

// File: rtl/status_pkt_gen.sv
module status_pkt_gen
  import status_pkt_pkg::*;
#(
  parameter int         PAYLOAD_BITS = 15,
  parameter logic [7:0] STATUS_ADDR  = 8'h31
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctrl_we,
  input  logic [7:0]              ctrl_data,
  input  logic [PAYLOAD_BITS-1:0] status,
  output logic [7:0]              pkt_byte,
  output logic                    pkt_req,
  input  logic                    pkt_start
);

  localparam int SEQ_W = 6;
  localparam int NT    = trail_bytes(PAYLOAD_BITS);
  localparam int IW    = $clog2(NT + 2);

  logic                    send_pending;
  logic [SEQ_W-1:0]        seq;
  logic [PAYLOAD_BITS-1:0] snap;
  logic [IW-1:0]           idx;
  logic [7:0]              trail_byte;
  logic                    pkt_taken;
  logic                    pkt_done;
  logic                    status_diff;

  assign status_diff = (status != snap);

  status_pkt_cfg #(.SEQ_W(SEQ_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .ctrl_data    (ctrl_data),
    .pkt_taken    (pkt_taken),
    .pkt_done     (pkt_done),
    .status_diff  (status_diff),
    .send_pending (send_pending),
    .seq          (seq)
  );

  status_pkt_bytes #(.PAYLOAD_BITS(PAYLOAD_BITS), .NT(NT), .IW(IW)) u_bytes (
    .snap       (snap),
    .idx        (idx),
    .trail_byte (trail_byte)
  );

  status_pkt_fsm #(
    .PAYLOAD_BITS (PAYLOAD_BITS),
    .STATUS_ADDR  (STATUS_ADDR),
    .SEQ_W        (SEQ_W),
    .NT           (NT),
    .IW           (IW)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .send_pending (send_pending),
    .pkt_start    (pkt_start),
    .status       (status),
    .seq          (seq),
    .trail_byte   (trail_byte),
    .pkt_req      (pkt_req),
    .pkt_byte     (pkt_byte),
    .snap         (snap),
    .idx          (idx),
    .pkt_taken    (pkt_taken),
    .pkt_done     (pkt_done)
  );

endmodule

// File: tb/status_pkt_gen_tb.sv
module status_pkt_gen_tb;

  localparam int P = 15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctrl_we = 1'b0;
  logic [7:0]   ctrl_data = 8'h00;
  logic [P-1:0] status = '0;
  logic [7:0]   pkt_byte;
  logic         pkt_req;
  logic         pkt_start = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  status_pkt_gen #(.PAYLOAD_BITS(P), .STATUS_ADDR(8'h31)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .ctrl_data (ctrl_data),
    .status    (status),
    .pkt_byte  (pkt_byte),
    .pkt_req   (pkt_req),
    .pkt_start (pkt_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] trail(input logic [P-1:0] st, input int j);
    logic [31:0] w;
    w = 32'(st) >> (8 * j - 6);
    return w[7:0];
  endfunction

  task automatic ctrl_write(input logic [5:0] sq, input logic [1:0] md);
    @(negedge clk);
    ctrl_we   = 1'b1;
    ctrl_data = {sq, md};
    @(negedge clk);
    ctrl_we   = 1'b0;
  endtask

  task automatic no_req(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pkt_req || pkt_byte != 8'h00) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  // waits for request, holds a few cycles, acknowledges and checks all bytes
  task automatic send_and_check(input string req, input logic [5:0] eseq,
                                input bit change_mid, input logic [P-1:0] newst);
    logic [P-1:0] st;
    int t = 0;
    while (!pkt_req && t < 50) begin
      @(negedge clk);
      t++;
    end
    check(pkt_req, {req, " R3 request"}, int'(pkt_req), 1);
    check(pkt_byte == 8'h31, "R3 address byte", pkt_byte, 8'h31);
    repeat (3) @(negedge clk);
    check(pkt_req && pkt_byte == 8'h31, "R3 request held", pkt_byte, 8'h31);
    st = status;
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    if (change_mid) status = newst;
    check(!pkt_req, "R4 request drop", int'(pkt_req), 0);
    check(pkt_byte == {eseq, st[1:0]}, {req, " R4 seq byte"}, pkt_byte, {eseq, st[1:0]});
    @(negedge clk);
    check(pkt_byte == trail(st, 1), "R4 R5 status byte 1", pkt_byte, trail(st, 1));
    @(negedge clk);
    check(pkt_byte == trail(st, 2), "R4 R5 status byte 2", pkt_byte, trail(st, 2));
    @(negedge clk);
    check(pkt_byte == 8'h00 && !pkt_req, "R4 bus idle", pkt_byte, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!pkt_req && pkt_byte == 8'h00, "R1 reset outputs", {pkt_req, pkt_byte}, 0);
    status = 15'h1234;
    no_req(10, "R1 no request after reset");
  endtask

  task automatic t_off_modes();
    ctrl_write(6'h2A, 2'd0);
    status = 15'h0F0F;
    no_req(15, "R9 mode 0 silent");
    ctrl_write(6'h15, 2'd2);
    status = 15'h7001;
    no_req(15, "R9 mode 2 silent");
  endtask

  task automatic t_once();
    status = 15'h5A5B;
    ctrl_write(6'd5, 2'd1);
    send_and_check("R2 R6 once", 6'd5, 1'b0, '0);
    status = 15'h1111;
    no_req(20, "R6 no second packet");
  endtask

  task automatic t_auto();
    status = 15'h3C3D;
    ctrl_write(6'h3F, 2'd3);
    send_and_check("R7 auto entry", 6'h3F, 1'b0, '0);
    no_req(10, "R7 stable status silent");
    status = 15'h6E92;
    send_and_check("R8 wrap to zero", 6'h00, 1'b1, 15'h0247);
    send_and_check("R7 follow-up after mid change", 6'h01, 1'b0, '0);
    no_req(10, "R7 quiet after follow-up");
  endtask

  task automatic t_reload();
    ctrl_write(6'h10, 2'd3);
    send_and_check("R8 R2 reload", 6'h10, 1'b0, '0);
    ctrl_write(6'h00, 2'd0);
    status = 15'h7FFF;
    no_req(10, "R9 off after auto");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_off_modes();
    t_once();
    t_auto();
    t_reload();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule